// File: doc/BRIEF.md
# Fetch/Data Region Arbiter

This block sits between a processor's two independent request streams and two single-ported memory regions: a Flash region and an internal RAM region. The fetch stream and the data stream each present a request with an address. When the two requests target different regions, both run in the same cycle. When they target the same region, the data request runs first and the fetch waits until the region is free again.

Flash reads are slowed by a 2-bit wait setting. Software chooses this setting from the system clock frequency, always picking a setting rated for a clock faster than the one actually in use. The data port also states how many bus cycles its access needs, which depends on the access width against the device width. An address that falls in neither region is finished at once.

Both request ports follow valid/ready rules. A requester raises valid and holds it, with its address and cycle count, until it sees ready. Ready is the back-pressure. It is high only in the last cycle of an access, and a requester may not withdraw or change a request while ready is low. The per-region grant outputs show which port occupies each region in every cycle. The memory arrays themselves are outside this block.

Top module: `fdarb_top`

## Requirements
- R1: Region decode uses inclusive parameter bounds. By default Flash is 0x8000 to 0x27FFF, which places 0x8000 in Flash, and RAM is 0x0 to 0x1FFF. Any other address is unmapped.
- R2: A fetch and a data access to different regions both start in the same cycle, and each completes after its own length with no stall.
- R3: When both ports need the Flash region, the two accesses are serialized.
- R4: When both ports need the RAM region, the two accesses are serialized.
- R5: When the ports request the same region in the same cycle, the data port takes the region. The waiting fetch starts in the cycle after the data access's ready, so it is lengthened by exactly the data access's cycle count, unless another data request for that region is already pending then.
- R6: A data access lasts data_cycles bus cycles. A value of 0 counts as 1. On RAM, each bus cycle takes one clock.
- R7: On Flash, each bus cycle takes 1 + flash_rd_wait clocks, on both ports. A fetch is one bus cycle. The wait value is sampled in the cycle the access starts.
- R8: An unmapped request, on either port, gets ready in the same cycle as valid and shows no grant.
- R9: Ready is high only while valid is high, and only in the last cycle of an access. An access that has started is never interrupted. A requester holds valid, address and cycle count stable until ready.
- R10: flash_grant and ram_grant use bit 0 for the fetch port and bit 1 for the data port. A bit is high in every cycle that port occupies the region. The two bits are never high together.
- R11: While reset is held, and with no requests, every ready and every grant is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_addr | input | AW | Fetch address |
| fetch_ready | output | 1 | Fetch completes this cycle |
| data_valid | input | 1 | Data request valid |
| data_addr | input | AW | Data address |
| data_cycles | input | CW | Bus cycles needed by the data access |
| data_ready | output | 1 | Data access completes this cycle |
| flash_rd_wait | input | 2 | Flash wait clocks added per bus cycle |
| flash_grant | output | 2 | Flash owner: bit 0 fetch, bit 1 data |
| ram_grant | output | 2 | RAM owner: bit 0 fetch, bit 1 data |

## Verification
The assertions assume that each requester obeys the hold rule: once valid is raised, valid, address and cycle count stay fixed until ready, and valid never falls early. The stimulus respects this by taking a request from its queue only while the port is idle. It drops or replaces a request only in the cycle after the reference model expects ready. The wait setting is allowed to change at any time, even in the middle of an access, to exercise the rule that the setting is sampled when an access starts.

// File: rtl/fdarb_pkg.sv
package fdarb_pkg;
  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_FLASH = 2'd1,
    RGN_RAM   = 2'd2
  } rgn_e;
endpackage

// File: rtl/fdarb_region_decode.sv
module fdarb_region_decode
  import fdarb_pkg::*;
#(
  parameter int unsigned     AW       = 24,
  parameter logic [AW-1:0]   FLASH_LO = 'h8000,
  parameter logic [AW-1:0]   FLASH_HI = 'h27FFF,
  parameter logic [AW-1:0]   RAM_LO   = 'h0,
  parameter logic [AW-1:0]   RAM_HI   = 'h1FFF
) (
  input  logic [AW-1:0] addr,
  output rgn_e          rgn
);
  logic in_flash, in_ram;

  assign in_flash = (addr >= FLASH_LO) && (addr <= FLASH_HI);
  assign in_ram   = (addr >= RAM_LO)   && (addr <= RAM_HI);

  // Flash takes precedence should the windows ever overlap.
  always_comb begin
    if (in_flash)    rgn = RGN_FLASH;
    else if (in_ram) rgn = RGN_RAM;
    else             rgn = RGN_NONE;
  end
endmodule

// File: rtl/fdarb_access_len.sv
module fdarb_access_len
  import fdarb_pkg::*;
#(
  parameter int unsigned CW = 3,
  localparam int unsigned LW = CW + 2
) (
  input  logic [CW-1:0] bus_cycles,
  input  rgn_e          rgn,
  input  logic [1:0]    wait_sel,
  output logic [LW-1:0] len
);
  logic [LW-1:0] bus_w, per_w;

  // Zero bus cycles counts as one; each Flash bus cycle stretches by the wait.
  assign bus_w = (bus_cycles == '0) ? LW'(1) : LW'(bus_cycles);
  assign per_w = (rgn == RGN_FLASH) ? (LW'(wait_sel) + LW'(1)) : LW'(1);

  // Unmapped accesses finish in a single clock regardless of width.
  assign len = (rgn == RGN_NONE) ? LW'(1) : LW'(bus_w * per_w);
endmodule

// File: rtl/fdarb_port_engine.sv
module fdarb_port_engine
  import fdarb_pkg::*;
#(
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [LW-1:0] len,
  input  rgn_e          rgn_in,
  output logic          start,
  output logic          ready,
  output logic          busy,
  output rgn_e          occ
);
  logic          busy_q;
  logic [LW-1:0] rem_q;
  rgn_e          cur_q;

  assign start = go && !busy_q;
  assign busy  = busy_q;
  assign ready = busy_q ? (rem_q == LW'(1)) : (start && (len == LW'(1)));
  assign occ   = busy_q ? cur_q : (start ? rgn_in : RGN_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      cur_q  <= RGN_NONE;
    end else if (busy_q) begin
      if (rem_q == LW'(1)) busy_q <= 1'b0;
      rem_q <= rem_q - LW'(1);
    end else if (start && (len > LW'(1))) begin
      busy_q <= 1'b1;
      rem_q  <= len - LW'(1);
      cur_q  <= rgn_in;
    end
  end

  // A running access always has cycles left to count.
  p_rem_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q != '0));

  // The last cycle of an access frees the engine.
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ready) |=> !busy_q);

  // An access in progress keeps its region until it finishes.
  p_hold_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready) |=> (busy_q && $stable(occ)));
endmodule

// File: rtl/fdarb_top.sv
module fdarb_top
  import fdarb_pkg::*;
#(
  parameter int unsigned   AW       = 24,
  parameter int unsigned   CW       = 3,
  parameter logic [AW-1:0] FLASH_LO = 'h8000,
  parameter logic [AW-1:0] FLASH_HI = 'h27FFF,
  parameter logic [AW-1:0] RAM_LO   = 'h0,
  parameter logic [AW-1:0] RAM_HI   = 'h1FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_ready,
  input  logic          data_valid,
  input  logic [AW-1:0] data_addr,
  input  logic [CW-1:0] data_cycles,
  output logic          data_ready,
  input  logic [1:0]    flash_rd_wait,
  output logic [1:0]    flash_grant,
  output logic [1:0]    ram_grant
);
  localparam int unsigned LW = CW + 2;

  rgn_e          f_rgn, d_rgn, f_occ, d_occ;
  logic [LW-1:0] f_len, d_len;
  logic          f_go, d_go, f_start, d_start, f_busy, d_busy;

  fdarb_region_decode #(.AW(AW), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI),
                        .RAM_LO(RAM_LO), .RAM_HI(RAM_HI))
    u_dec_f (.addr(fetch_addr), .rgn(f_rgn));
  fdarb_region_decode #(.AW(AW), .FLASH_LO(FLASH_LO), .FLASH_HI(FLASH_HI),
                        .RAM_LO(RAM_LO), .RAM_HI(RAM_HI))
    u_dec_d (.addr(data_addr), .rgn(d_rgn));

  // A fetch is a single bus cycle.
  fdarb_access_len #(.CW(CW)) u_len_f (
    .bus_cycles(CW'(1)), .rgn(f_rgn), .wait_sel(flash_rd_wait), .len(f_len));
  fdarb_access_len #(.CW(CW)) u_len_d (
    .bus_cycles(data_cycles), .rgn(d_rgn), .wait_sel(flash_rd_wait), .len(d_len));

  // Data may start unless a fetch already holds its region.
  assign d_go = data_valid &&
                ((d_rgn == RGN_NONE) || !(f_busy && (f_occ == d_rgn)));

  // Fetch yields to a running data access and to one starting this cycle.
  assign f_go = fetch_valid &&
                ((f_rgn == RGN_NONE) ||
                 !((d_busy && (d_occ == f_rgn)) || (d_start && (d_rgn == f_rgn))));

  fdarb_port_engine #(.LW(LW)) u_eng_d (
    .clk(clk), .rst_n(rst_n), .go(d_go), .len(d_len), .rgn_in(d_rgn),
    .start(d_start), .ready(data_ready), .busy(d_busy), .occ(d_occ));
  fdarb_port_engine #(.LW(LW)) u_eng_f (
    .clk(clk), .rst_n(rst_n), .go(f_go), .len(f_len), .rgn_in(f_rgn),
    .start(f_start), .ready(fetch_ready), .busy(f_busy), .occ(f_occ));

  assign flash_grant = {d_occ == RGN_FLASH, f_occ == RGN_FLASH};
  assign ram_grant   = {d_occ == RGN_RAM,   f_occ == RGN_RAM};

  p_flash_one_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flash_grant != 2'b11);
  p_ram_one_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_grant != 2'b11);

  p_data_first_flash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && data_valid && !f_busy && !d_busy &&
     f_rgn == RGN_FLASH && d_rgn == RGN_FLASH) |-> (flash_grant == 2'b10));
  p_data_first_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && data_valid && !f_busy && !d_busy &&
     f_rgn == RGN_RAM && d_rgn == RGN_RAM) |-> (ram_grant == 2'b10));

  p_unmapped_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !d_busy && d_rgn == RGN_NONE) |-> (data_ready && !flash_grant[1] && !ram_grant[1]));

  p_fready_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> fetch_valid);
  p_dready_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> data_valid);

  p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !data_ready) |=>
      (data_valid && $stable(data_addr) && $stable(data_cycles)));
endmodule

// File: tb/tb_fdarb_top.sv
module tb_fdarb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [23:0] fetch_addr = '0;
  logic        fetch_ready;
  logic        data_valid = 1'b0;
  logic [23:0] data_addr = '0;
  logic [2:0]  data_cycles = '0;
  logic        data_ready;
  logic [1:0]  flash_rd_wait = '0;
  logic [1:0]  flash_grant, ram_grant;

  always #2.5 clk = ~clk;

  fdarb_top dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .data_valid(data_valid), .data_addr(data_addr), .data_cycles(data_cycles),
    .data_ready(data_ready), .flash_rd_wait(flash_rd_wait),
    .flash_grant(flash_grant), .ram_grant(ram_grant));

  int n_chk = 0;
  int n_bad = 0;

  // Reference state: busy flag, clocks left, region (0 none, 1 flash, 2 ram).
  int fb = 0, frem = 0, frg = 0;
  int db = 0, drem = 0, drg = 0;

  typedef struct { logic [23:0] a; int c; } dreq_t;
  logic [23:0] fq[$];
  dreq_t       dq[$];
  int gap = 0;
  bit wobble = 0;

  function automatic int rgn_of(logic [23:0] a);
    if (a >= 24'h8000 && a <= 24'h27FFF) return 1;
    if (a <= 24'h1FFF) return 2;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    int fr, dr, dl, fl, eff_c;
    bit ds, fs, er_d, er_f;
    int ef, er;
    string ftag, dtag;
    @(negedge clk);
    fr = rgn_of(fetch_addr);
    dr = rgn_of(data_addr);
    eff_c = (data_cycles == 0) ? 1 : int'(data_cycles);
    dl = (dr == 0) ? 1 : eff_c * ((dr == 1) ? int'(flash_rd_wait) + 1 : 1);
    fl = (fr == 1) ? int'(flash_rd_wait) + 1 : 1;
    ds = data_valid && !db && (dr == 0 || !(fb && frg == dr));
    fs = fetch_valid && !fb &&
         (fr == 0 || !((db && drg == fr) || (ds && dr == fr)));
    er_d = db ? (drem == 1) : (ds && dl == 1);
    er_f = fb ? (frem == 1) : (fs && fl == 1);
    // Each port's region this cycle.
    ef = fb ? frg : (fs ? fr : 0);
    er = db ? drg : (ds ? dr : 0);

    if (!data_valid)     dtag = "R9";
    else if (dr == 0)    dtag = "R8";
    else if (dr == 1)    dtag = "R7";
    else                 dtag = "R6";
    if (!fetch_valid)    ftag = "R9";
    else if (fr == 0)    ftag = "R8";
    else if (fetch_valid && !fb && ((db && drg == fr) || (ds && dr == fr)))
      ftag = (fr == 1) ? "R3 R5" : "R4 R5";
    else if (fr == 1)    ftag = "R7 R2";
    else                 ftag = "R2";

    chk(dtag, "data_ready", int'(data_ready), int'(er_d));
    chk(ftag, "fetch_ready", int'(fetch_ready), int'(er_f));
    chk("R1 R10", "flash_grant[0]", int'(flash_grant[0]), int'(ef == 1));
    chk("R1 R10", "flash_grant[1]", int'(flash_grant[1]), int'(er == 1));
    chk("R1 R10", "ram_grant[0]", int'(ram_grant[0]), int'(ef == 2));
    chk("R1 R10", "ram_grant[1]", int'(ram_grant[1]), int'(er == 2));

    @(posedge clk);
    #1;
    // Advance the reference.
    if (db) begin
      if (drem == 1) db = 0;
      drem--;
    end else if (ds && dl > 1) begin
      db = 1; drem = dl - 1; drg = dr;
    end
    if (fb) begin
      if (frem == 1) fb = 0;
      frem--;
    end else if (fs && fl > 1) begin
      fb = 1; frem = fl - 1; frg = fr;
    end
    // Requesters: drop after ready, then maybe issue the next one.
    if (er_d) data_valid = 1'b0;
    if (er_f) fetch_valid = 1'b0;
    if (!data_valid && dq.size() > 0 && ($urandom_range(99) >= gap)) begin
      dreq_t r = dq.pop_front();
      data_valid = 1'b1; data_addr = r.a; data_cycles = 3'(r.c);
    end
    if (!fetch_valid && fq.size() > 0 && ($urandom_range(99) >= gap)) begin
      fetch_valid = 1'b1; fetch_addr = fq.pop_front();
    end
    if (wobble && $urandom_range(9) == 0) flash_rd_wait = 2'($urandom_range(3));
  endtask

  task automatic drain();
    int guard = 0;
    while ((fq.size() > 0 || dq.size() > 0 || fetch_valid || data_valid || fb || db)
           && guard < 20000) begin
      step();
      guard++;
    end
    repeat (2) step();
  endtask

  function automatic logic [23:0] pick_addr(int kind);
    case (kind)
      0:       return 24'h30000 + 24'($urandom_range(24'hFFFF));
      1:       return 24'h8000 + 24'($urandom_range(24'h1FFFF));
      default: return 24'($urandom_range(24'h1FFF));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R11: quiet outputs during reset.
    repeat (3) begin
      @(negedge clk);
      chk("R11", "fetch_ready", int'(fetch_ready), 0);
      chk("R11", "data_ready", int'(data_ready), 0);
      chk("R11", "flash_grant", int'(flash_grant), 0);
      chk("R11", "ram_grant", int'(ram_grant), 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 R2: vector-base fetch from Flash alongside a RAM data access.
    flash_rd_wait = 2'd0;
    fq.push_back(24'h8000);     dq.push_back('{24'h0100, 2});
    fq.push_back(24'h1FFF);     dq.push_back('{24'h27FFF, 1});
    fq.push_back(24'h7FFF);     dq.push_back('{24'h28000, 3});
    drain();

    // R3 R5 R7: both on Flash, several wait settings.
    for (int w = 0; w < 4; w++) begin
      flash_rd_wait = 2'(w);
      fq.push_back(24'h9000); dq.push_back('{24'hA000, 2});
      fq.push_back(24'h9004); dq.push_back('{24'hA004, 1});
      drain();
    end

    // R4 R5 R6: both on RAM, widest data accesses and a zero count.
    fq.push_back(24'h0010); dq.push_back('{24'h0200, 4});
    fq.push_back(24'h0014); dq.push_back('{24'h0204, 0});
    fq.push_back(24'h0018); dq.push_back('{24'h0208, 7});
    drain();

    // R8: unmapped on both ports.
    fq.push_back(24'h40000); dq.push_back('{24'hFFFFFF, 4});
    fq.push_back(24'h2000);  dq.push_back('{24'h50000, 7});
    drain();

    // R7 R9: mixed traffic with gaps and the wait setting changing mid-access.
    gap = 30; wobble = 1;
    for (int i = 0; i < 400; i++) begin
      fq.push_back(pick_addr($urandom_range(5) == 0 ? 0 : 1 + $urandom_range(1)));
      dq.push_back('{pick_addr($urandom_range(5) == 0 ? 0 : 1 + $urandom_range(1)),
                     $urandom_range(4)});
    end
    drain();

    // Back-to-back contention with no gaps.
    gap = 0;
    for (int i = 0; i < 200; i++) begin
      fq.push_back(pick_addr(1 + $urandom_range(1)));
      dq.push_back('{pick_addr(1 + $urandom_range(1)), $urandom_range(7)});
    end
    drain();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule